// File: doc/BRIEF.md
# SMBus Host Block-Transfer Controller

This block is the host side of an SMBus port. Software sees it as a set of byte-wide registers. Software loads a target address, a command byte and a block payload, then writes a start request to run an SMBus block write or block read. A transaction sequencer turns that request into byte-level operations: bus start, byte send, byte receive with ACK or NACK, and bus stop. It passes each operation over a simple request/done handshake to a bit-level serial engine outside the block.

Payload bytes pass through a 32-entry buffer behind a single data port whose index auto-increments. A read of the control register rewinds that index to zero. The byte count of a block lives in DATA0: software writes it for a block write, and the sequencer fills it in for a block read. Completion and errors are reported as sticky status bits that software clears by writing 1 to them.

The sequencer states are:

| State | Role |
|---|---|
| SQ_IDLE | No transaction is in progress. |
| SQ_START | Bus start. |
| SQ_ADDR_W | Address byte with the write bit. |
| SQ_CMD | Command byte. |
| SQ_CNT_TX | Count byte sent (block write). |
| SQ_DATA_TX | Payload bytes sent (block write). |
| SQ_RESTART | Repeated start (block read). |
| SQ_ADDR_R | Address byte with the read bit. |
| SQ_CNT_RX | Count byte received. |
| SQ_DATA_RX | Payload bytes received. |
| SQ_STOP | Bus stop. |
| SQ_END | One-cycle result report. |

The transitions are:

- SQ_IDLE→SQ_START on an accepted start request.
- SQ_IDLE→SQ_END on a block write with an illegal count.
- SQ_START→SQ_ADDR_W→SQ_CMD.
- SQ_CMD→SQ_CNT_TX for a write.
- SQ_CMD→SQ_RESTART for a read.
- SQ_CNT_TX→SQ_DATA_TX.
- SQ_DATA_TX loops on itself until the last byte, then goes to SQ_STOP.
- SQ_RESTART→SQ_ADDR_R→SQ_CNT_RX.
- SQ_CNT_RX→SQ_DATA_RX on a legal count, or SQ_CNT_RX→SQ_STOP on an illegal one.
- SQ_DATA_RX loops on itself until the last byte, then goes to SQ_STOP.
- Any byte state→SQ_STOP on a NACK or a kill request.
- SQ_STOP→SQ_END→SQ_IDLE.

Top module: `smbus_host_regs`

## Requirements
- R1: Register offsets are:
  - status 0x0
  - control 0x2
  - command 0x3
  - target address 0x4
  - DATA0 0x5
  - DATA1 0x6
  - block data 0x7
  - auxiliary 0xD

  After reset every register reads 0. Reads take effect on the clock edge that samples the read strobe, and the data appears on the following cycle.
- R2: Any read of the control register sets the block buffer index to 0. Each write to block data stores the byte at the index and then increments it. Each read of block data returns the byte at the index and then increments it.
- R3: Control bits are:
  - interrupt enable, bit0 (stored only)
  - kill, bit1
  - protocol, bits 4:2
  - last byte, bit5 (stored only)
  - start, bit6
  - PEC enable, bit7 (stored only)

  A start request is accepted only when all of these hold: HOST_BUSY is 0, the written protocol is 3'b101, and auxiliary bit1 (32-byte buffer enable) is 1. Otherwise it is ignored. The start bit always reads back as 0.
- R4: For a block write, the byte operations go out in this order:
  1. bus start
  2. {addr[7:1],0}
  3. command
  4. DATA0 count
  5. DATA0 buffer bytes from entry 0 upward
  6. bus stop

  Engine op codes are start=0, write=1, read=2, stop=3.
- R5: For a block read, the byte operations go out in this order:
  1. bus start
  2. {addr[7:1],0}
  3. command
  4. repeated start
  5. {addr[7:1],1}
  6. a count byte read
  7. that many byte reads, stored from buffer entry 0
  8. bus stop

  Only the last byte read carries NACK. The received count is placed in DATA0.
- R6: Status bit0 (HOST_BUSY) is 1 from the accepted start until the transaction ends. The block makes engine requests only while busy.
- R7: Status bits are:
  - INTR, bit1: set only on a transaction that completes without error.
  - DEV_ERR, bit2
  - FAILED, bit4

  Writing 1 to INTR, DEV_ERR or FAILED clears that bit. Bits 3, 5, 6 and 7 read as 0.
- R8: If any sent byte is not acknowledged, the sequencer sends no further bytes, issues bus stop, and sets DEV_ERR without INTR.
- R9: A received block count of 0 or above 32 sets DEV_ERR. The sequencer then reads no payload and goes straight to bus stop. A block write whose DATA0 is 0 or above 32 sets DEV_ERR with no bus activity.
- R10: A kill bit set during a transaction ends it at the next byte boundary with bus stop. HOST_BUSY clears and FAILED is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after the strobe |
| eng_req | output | 1 | Byte operation request to the serial engine |
| eng_op | output | 2 | Operation: 0 start, 1 write, 2 read, 3 stop |
| eng_wbyte | output | 8 | Byte to send for a write operation |
| eng_nack | output | 1 | Answer a read operation with NACK |
| eng_done | input | 1 | One-cycle pulse that ends the current operation |
| eng_ack | input | 1 | Target acknowledged the byte sent (valid with done) |
| eng_rbyte | input | 8 | Byte received by a read operation (valid with done) |

## Verification
The bench builds the block with its default 32-entry buffer. This brings full-length 32-byte reads and writes within reach, along with the count-33 rejection just past the buffer end. A behavioural engine model in the bench can refuse any chosen byte and can return any count byte. This exercises NACK on the address and on payload bytes, zero and oversize counts, a kill in the middle of a long write, and a second start request written while the first is still running.

// File: rtl/smbus_host_pkg.sv
package smbus_host_pkg;

    localparam int BYTE_W = 8;

    localparam logic [3:0] OFF_STATUS = 4'h0;
    localparam logic [3:0] OFF_CTRL   = 4'h2;
    localparam logic [3:0] OFF_CMD    = 4'h3;
    localparam logic [3:0] OFF_XADDR  = 4'h4;
    localparam logic [3:0] OFF_DATA0  = 4'h5;
    localparam logic [3:0] OFF_DATA1  = 4'h6;
    localparam logic [3:0] OFF_BLK    = 4'h7;
    localparam logic [3:0] OFF_AUX    = 4'hD;

    localparam logic [2:0] PROTO_BLOCK = 3'b101;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } eng_op_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_START,
        SQ_ADDR_W,
        SQ_CMD,
        SQ_CNT_TX,
        SQ_DATA_TX,
        SQ_RESTART,
        SQ_ADDR_R,
        SQ_CNT_RX,
        SQ_DATA_RX,
        SQ_STOP,
        SQ_END
    } seq_state_e;

    typedef struct packed {
        logic ok;
        logic dev_err;
        logic failed;
    } xact_result_t;

endpackage

// File: rtl/smbus_blk_buf.sv
module smbus_blk_buf
    import smbus_host_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_clr,
    input  logic              sw_wr,
    input  logic              sw_rd,
    input  logic [BYTE_W-1:0] sw_wdata,
    output logic [BYTE_W-1:0] sw_rdata,
    output logic [IW-1:0]     sw_idx,
    input  logic              seq_wr,
    input  logic [IW-1:0]     seq_idx,
    input  logic [BYTE_W-1:0] seq_wdata,
    output logic [BYTE_W-1:0] seq_rdata
);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [IW-1:0]     idx_q;

    // Software-side cursor: rewound by a control read, stepped by data-port access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (idx_clr) begin
            idx_q <= '0;
        end else if (sw_wr || sw_rd) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Sequencer writes land after software writes, so they win a same-slot collision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (sw_wr) begin
                mem[idx_q] <= sw_wdata;
            end
            if (seq_wr) begin
                mem[seq_idx] <= seq_wdata;
            end
        end
    end

    assign sw_rdata  = mem[idx_q];
    assign seq_rdata = mem[seq_idx];
    assign sw_idx    = idx_q;

endmodule

// File: rtl/smbus_xact_fsm.sv
module smbus_xact_fsm
    import smbus_host_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [BYTE_W-1:0] xaddr,
    input  logic [BYTE_W-1:0] cmd,
    input  logic [BYTE_W-1:0] wr_count,
    input  logic              kill,
    input  logic              eng_done,
    input  logic              eng_ack,
    input  logic [BYTE_W-1:0] eng_rbyte,
    input  logic [BYTE_W-1:0] buf_rdata,
    output logic              busy,
    output logic              eng_req,
    output eng_op_e           eng_op,
    output logic [BYTE_W-1:0] eng_wbyte,
    output logic              eng_nack,
    output logic [IW-1:0]     buf_idx,
    output logic              buf_we,
    output logic [BYTE_W-1:0] buf_wdata,
    output logic              cnt_we,
    output logic [BYTE_W-1:0] cnt_wdata,
    output logic              fin,
    output xact_result_t      result
);

    seq_state_e        state_q, state_d, step_next;
    logic [CW-1:0]     cnt_q;
    logic [BYTE_W-1:0] total_q;
    logic              rd_q, err_q, kill_q;
    logic              last_byte, sending, nack_now, bad_wr_len, rx_len_ok;

    function automatic logic len_ok(input logic [BYTE_W-1:0] v);
        return (v != '0) && (int'(v) <= DEPTH);
    endfunction

    assign last_byte  = ((BYTE_W'(cnt_q) + 1'b1) == total_q);
    assign sending    = (state_q == SQ_ADDR_W) || (state_q == SQ_CMD) ||
                        (state_q == SQ_CNT_TX) || (state_q == SQ_DATA_TX) ||
                        (state_q == SQ_ADDR_R);
    assign nack_now   = sending && !eng_ack;
    assign bad_wr_len = !xaddr[0] && !len_ok(wr_count);
    assign rx_len_ok  = len_ok(eng_rbyte);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Successor of each byte state on a normal completion
    always_comb begin
        step_next = SQ_STOP;
        unique case (state_q)
            SQ_START:   step_next = SQ_ADDR_W;
            SQ_ADDR_W:  step_next = SQ_CMD;
            SQ_CMD:     step_next = rd_q ? SQ_RESTART : SQ_CNT_TX;
            SQ_CNT_TX:  step_next = SQ_DATA_TX;
            SQ_DATA_TX: step_next = last_byte ? SQ_STOP : SQ_DATA_TX;
            SQ_RESTART: step_next = SQ_ADDR_R;
            SQ_ADDR_R:  step_next = SQ_CNT_RX;
            SQ_CNT_RX:  step_next = rx_len_ok ? SQ_DATA_RX : SQ_STOP;
            SQ_DATA_RX: step_next = last_byte ? SQ_STOP : SQ_DATA_RX;
            default:    step_next = SQ_STOP;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: if (go) state_d = bad_wr_len ? SQ_END : SQ_START;
            SQ_STOP: if (eng_done) state_d = SQ_END;
            SQ_END:  state_d = SQ_IDLE;
            default: if (eng_done) state_d = (kill || nack_now) ? SQ_STOP : step_next;
        endcase
    end

    // Transaction context: direction, counts, error flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            total_q <= '0;
            rd_q    <= 1'b0;
            err_q   <= 1'b0;
            kill_q  <= 1'b0;
        end else if (state_q == SQ_IDLE) begin
            if (go) begin
                cnt_q   <= '0;
                rd_q    <= xaddr[0];
                total_q <= xaddr[0] ? '0 : wr_count;
                err_q   <= bad_wr_len;
                kill_q  <= 1'b0;
            end
        end else if (eng_done && state_q != SQ_END) begin
            if (state_q == SQ_DATA_TX || state_q == SQ_DATA_RX) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == SQ_CNT_RX) begin
                total_q <= eng_rbyte;
                if (!rx_len_ok) err_q <= 1'b1;
            end
            if (nack_now) begin
                err_q <= 1'b1;
            end
            if (kill && state_q != SQ_STOP) begin
                kill_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        eng_req   = 1'b0;
        eng_op    = OP_STOP;
        eng_wbyte = '0;
        eng_nack  = 1'b0;
        unique case (state_q)
            SQ_IDLE, SQ_END: eng_req = 1'b0;
            SQ_START, SQ_RESTART: begin
                eng_req = 1'b1;
                eng_op  = OP_START;
            end
            SQ_ADDR_W: begin
                eng_req   = 1'b1;
                eng_op    = OP_WRITE;
                eng_wbyte = {xaddr[7:1], 1'b0};
            end
            SQ_ADDR_R: begin
                eng_req   = 1'b1;
                eng_op    = OP_WRITE;
                eng_wbyte = {xaddr[7:1], 1'b1};
            end
            SQ_CMD: begin
                eng_req   = 1'b1;
                eng_op    = OP_WRITE;
                eng_wbyte = cmd;
            end
            SQ_CNT_TX: begin
                eng_req   = 1'b1;
                eng_op    = OP_WRITE;
                eng_wbyte = total_q;
            end
            SQ_DATA_TX: begin
                eng_req   = 1'b1;
                eng_op    = OP_WRITE;
                eng_wbyte = buf_rdata;
            end
            SQ_CNT_RX: begin
                eng_req = 1'b1;
                eng_op  = OP_READ;
            end
            SQ_DATA_RX: begin
                eng_req  = 1'b1;
                eng_op   = OP_READ;
                eng_nack = last_byte;
            end
            SQ_STOP: begin
                eng_req = 1'b1;
                eng_op  = OP_STOP;
            end
        endcase
    end

    assign busy           = (state_q != SQ_IDLE);
    assign fin            = (state_q == SQ_END);
    assign buf_idx        = cnt_q[IW-1:0];
    assign buf_we         = (state_q == SQ_DATA_RX) && eng_done;
    assign buf_wdata      = eng_rbyte;
    assign cnt_we         = (state_q == SQ_CNT_RX) && eng_done;
    assign cnt_wdata      = eng_rbyte;
    assign result.ok      = !err_q && !kill_q;
    assign result.dev_err = err_q;
    assign result.failed  = kill_q;

endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
    import smbus_host_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_rd,
    input  logic       reg_wr,
    input  logic [3:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       eng_req,
    output logic [1:0] eng_op,
    output logic [7:0] eng_wbyte,
    output logic       eng_nack,
    input  logic       eng_done,
    input  logic       eng_ack,
    input  logic [7:0] eng_rbyte
);

    localparam int IW = $clog2(DEPTH);

    logic              ctl_ien, ctl_kill, ctl_last, ctl_pec;
    logic [2:0]        ctl_proto;
    logic [BYTE_W-1:0] cmd_q, xaddr_q, data0_q, data1_q;
    logic [1:0]        aux_q;
    logic              st_intr, st_deverr, st_failed;

    logic              host_busy, seq_fin, seq_buf_we, seq_cnt_we;
    xact_result_t      seq_res;
    eng_op_e           seq_op;
    logic [IW-1:0]     seq_buf_idx, buf_sw_idx;
    logic [BYTE_W-1:0] seq_buf_wdata, seq_cnt_wdata, seq_buf_rdata, sw_buf_rdata;
    logic              wr_ctrl, rd_ctrl, start_go;
    logic [7:0]        status_v, ctrl_v;

    assign wr_ctrl  = reg_wr && (reg_addr == OFF_CTRL);
    assign rd_ctrl  = reg_rd && (reg_addr == OFF_CTRL);
    assign start_go = wr_ctrl && reg_wdata[6] && !host_busy &&
                      (reg_wdata[4:2] == PROTO_BLOCK) && aux_q[1];

    smbus_blk_buf #(.DEPTH(DEPTH)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_clr   (rd_ctrl),
        .sw_wr     (reg_wr && (reg_addr == OFF_BLK)),
        .sw_rd     (reg_rd && (reg_addr == OFF_BLK)),
        .sw_wdata  (reg_wdata),
        .sw_rdata  (sw_buf_rdata),
        .sw_idx    (buf_sw_idx),
        .seq_wr    (seq_buf_we),
        .seq_idx   (seq_buf_idx),
        .seq_wdata (seq_buf_wdata),
        .seq_rdata (seq_buf_rdata)
    );

    smbus_xact_fsm #(.DEPTH(DEPTH)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (start_go),
        .xaddr     (xaddr_q),
        .cmd       (cmd_q),
        .wr_count  (data0_q),
        .kill      (ctl_kill),
        .eng_done  (eng_done),
        .eng_ack   (eng_ack),
        .eng_rbyte (eng_rbyte),
        .buf_rdata (seq_buf_rdata),
        .busy      (host_busy),
        .eng_req   (eng_req),
        .eng_op    (seq_op),
        .eng_wbyte (eng_wbyte),
        .eng_nack  (eng_nack),
        .buf_idx   (seq_buf_idx),
        .buf_we    (seq_buf_we),
        .buf_wdata (seq_buf_wdata),
        .cnt_we    (seq_cnt_we),
        .cnt_wdata (seq_cnt_wdata),
        .fin       (seq_fin),
        .result    (seq_res)
    );

    assign eng_op = seq_op;

    // Plain storage registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_ien   <= 1'b0;
            ctl_kill  <= 1'b0;
            ctl_proto <= '0;
            ctl_last  <= 1'b0;
            ctl_pec   <= 1'b0;
            cmd_q     <= '0;
            xaddr_q   <= '0;
            data0_q   <= '0;
            data1_q   <= '0;
            aux_q     <= '0;
        end else begin
            if (wr_ctrl) begin
                ctl_ien   <= reg_wdata[0];
                ctl_kill  <= reg_wdata[1];
                ctl_proto <= reg_wdata[4:2];
                ctl_last  <= reg_wdata[5];
                ctl_pec   <= reg_wdata[7];
            end
            if (reg_wr && reg_addr == OFF_CMD)   cmd_q   <= reg_wdata;
            if (reg_wr && reg_addr == OFF_XADDR) xaddr_q <= reg_wdata;
            if (reg_wr && reg_addr == OFF_DATA1) data1_q <= reg_wdata;
            if (reg_wr && reg_addr == OFF_AUX)   aux_q   <= reg_wdata[1:0];
            if (seq_cnt_we) begin
                data0_q <= seq_cnt_wdata;
            end else if (reg_wr && reg_addr == OFF_DATA0) begin
                data0_q <= reg_wdata;
            end
        end
    end

    // Sticky status: completion sets, write-one clears, set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_intr   <= 1'b0;
            st_deverr <= 1'b0;
            st_failed <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == OFF_STATUS) begin
                if (reg_wdata[1]) st_intr   <= 1'b0;
                if (reg_wdata[2]) st_deverr <= 1'b0;
                if (reg_wdata[4]) st_failed <= 1'b0;
            end
            if (seq_fin) begin
                if (seq_res.ok)      st_intr   <= 1'b1;
                if (seq_res.dev_err) st_deverr <= 1'b1;
                if (seq_res.failed)  st_failed <= 1'b1;
            end
        end
    end

    assign status_v = {3'b000, st_failed, 1'b0, st_deverr, st_intr, host_busy};
    assign ctrl_v   = {ctl_pec, 1'b0, ctl_last, ctl_proto, ctl_kill, ctl_ien};

    // Registered read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (reg_addr)
                OFF_STATUS: reg_rdata <= status_v;
                OFF_CTRL:   reg_rdata <= ctrl_v;
                OFF_CMD:    reg_rdata <= cmd_q;
                OFF_XADDR:  reg_rdata <= xaddr_q;
                OFF_DATA0:  reg_rdata <= data0_q;
                OFF_DATA1:  reg_rdata <= data1_q;
                OFF_BLK:    reg_rdata <= sw_buf_rdata;
                OFF_AUX:    reg_rdata <= {6'b0, aux_q};
                default:    reg_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/smbus_host_chk.sv
module smbus_host_chk #(
    parameter int IW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_rd,
    input logic          reg_wr,
    input logic [3:0]    reg_addr,
    input logic [7:0]    reg_wdata,
    input logic          eng_req,
    input logic          busy,
    input logic          fin,
    input logic          st_intr,
    input logic [IW-1:0] sw_idx
);

    AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> busy);  // R6

    AST_FIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);  // R6

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr && reg_addr == 4'h2 && reg_wdata[6]));  // R3

    AST_INTR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_intr) |-> $fell(busy));  // R7

    AST_IDX_REWOUND: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_rd && reg_addr == 4'h2) |-> (sw_idx == '0));  // R2

endmodule

bind smbus_host_regs smbus_host_chk #(.IW($clog2(DEPTH))) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .eng_req   (eng_req),
    .busy      (host_busy),
    .fin       (seq_fin),
    .st_intr   (st_intr),
    .sw_idx    (buf_sw_idx)
);

// File: tb/smbus_host_regs_bench.sv
`timescale 1ns/1ps
module smbus_host_regs_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_rd = 1'b0, reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       eng_req, eng_nack;
    logic [1:0] eng_op;
    logic [7:0] eng_wbyte;
    logic       eng_done = 1'b0, eng_ack = 1'b1;
    logic [7:0] eng_rbyte = '0;

    int nchk = 0, nfail = 0;

    // Engine model state
    int   wlog [64];
    int   wcnt, starts, stops, reads, nacks, last_nack, rpos;
    int   nack_at = -1;
    int   rd_cnt_byte = 0;
    logic [7:0] seed = 8'h00;
    int   dly = 0;
    logic cool = 1'b0;

    // Vector fields: [23] read, [22:16] target, [15:8] command, [7:0] length
    localparam logic [23:0] VEC [6] = '{
        {1'b0, 7'h21, 8'h10, 8'd1},
        {1'b0, 7'h50, 8'hA3, 8'd32},
        {1'b0, 7'h0F, 8'h44, 8'd5},
        {1'b1, 7'h33, 8'h02, 8'd1},
        {1'b1, 7'h7E, 8'hF0, 8'd32},
        {1'b1, 7'h12, 8'h81, 8'd7}
    };

    always #2.5 clk = ~clk;

    smbus_host_regs u_smbus_host_regs (
        .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_req(eng_req), .eng_op(eng_op), .eng_wbyte(eng_wbyte),
        .eng_nack(eng_nack), .eng_done(eng_done), .eng_ack(eng_ack),
        .eng_rbyte(eng_rbyte)
    );

    function automatic logic [7:0] pat(input logic [7:0] s, input int i);
        return 8'(int'(s) + i * 37 + 3);
    endfunction

    // Behavioural byte engine: 3-cycle operations, one idle cycle after each done
    always @(posedge clk) begin
        if (!rst_n) begin
            eng_done <= 1'b0;
            dly = 0;
            cool = 1'b0;
        end else begin
            eng_done <= 1'b0;
            if (cool) begin
                cool = 1'b0;
            end else if (dly != 0) begin
                dly = dly - 1;
                if (dly == 0) begin
                    eng_done <= 1'b1;
                    cool = 1'b1;
                end
            end else if (eng_req) begin
                dly = 3;
                case (eng_op)
                    2'd0: starts++;
                    2'd1: begin
                        if (wcnt < 64) wlog[wcnt] = int'(eng_wbyte);
                        eng_ack <= (wcnt != nack_at);
                        wcnt++;
                    end
                    2'd2: begin
                        eng_rbyte <= (rpos == 0) ? 8'(rd_cnt_byte) : pat(seed, rpos - 1);
                        rpos++;
                        reads++;
                        if (eng_nack) nacks++;
                        last_nack = int'(eng_nack);
                    end
                    default: stops++;
                endcase
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic clear_log();
        wcnt = 0; starts = 0; stops = 0; reads = 0; nacks = 0;
        last_nack = 0; rpos = 0; nack_at = -1;
        for (int i = 0; i < 64; i++) wlog[i] = -1;
    endtask

    task automatic wait_idle(output logic [7:0] s);
        for (int i = 0; i < 3000; i++) begin
            rd(4'h0, s);
            if (!s[0]) break;
        end
    endtask

    task automatic setup_write(input logic [6:0] a, input logic [7:0] c, input int len);
        logic [7:0] d;
        clear_log();
        rd(4'h2, d);
        wr(4'h5, 8'(len));
        for (int i = 0; i < len && i < 32; i++) wr(4'h7, pat(seed, i));
        wr(4'h4, {a, 1'b0});
        wr(4'h3, c);
        wr(4'h0, 8'h16);
    endtask

    task automatic setup_read(input logic [6:0] a, input logic [7:0] c, input int len);
        clear_log();
        rd_cnt_byte = len;
        wr(4'h4, {a, 1'b1});
        wr(4'h3, c);
        wr(4'h0, 8'h16);
    endtask

    initial begin
        #(5.0 * 150000);
        nfail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] d, s;
        clear_log();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: every register reads zero after reset
        foreach (VEC[k]) begin end
        rd(4'h0, d); chk("R1 status", d, 0);
        rd(4'h2, d); chk("R1 control", d, 0);
        rd(4'h3, d); chk("R1 command", d, 0);
        rd(4'h4, d); chk("R1 address", d, 0);
        rd(4'h5, d); chk("R1 data0", d, 0);
        rd(4'h6, d); chk("R1 data1", d, 0);
        rd(4'hD, d); chk("R1 aux", d, 0);

        wr(4'hD, 8'h02);
        rd(4'hD, d); chk("R1 aux store", d, 2);

        // Vector table: block writes and reads
        for (int v = 0; v < 6; v++) begin
            logic       isr;
            logic [6:0] ta;
            logic [7:0] cm;
            int         ln;
            isr = VEC[v][23]; ta = VEC[v][22:16]; cm = VEC[v][15:8]; ln = int'(VEC[v][7:0]);
            seed = 8'(v * 17 + 1);
            if (!isr) begin
                setup_write(ta, cm, ln);
                wr(4'h2, 8'h54);
                rd(4'h0, s); chk("R6 busy after start", int'(s[0]), 1);
                wait_idle(s);
                chk("R7 write intr", s, 8'h02);
                chk("R4 starts", starts, 1);
                chk("R4 stops", stops, 1);
                chk("R4 byte count", wcnt, ln + 3);
                chk("R4 addr byte", wlog[0], {ta, 1'b0});
                chk("R4 cmd byte", wlog[1], cm);
                chk("R4 count byte", wlog[2], ln);
                for (int i = 0; i < ln; i++) chk("R4 payload", wlog[3 + i], pat(seed, i));
            end else begin
                setup_read(ta, cm, ln);
                wr(4'h2, 8'h54);
                wait_idle(s);
                chk("R7 read intr", s, 8'h02);
                chk("R5 starts", starts, 2);
                chk("R5 stops", stops, 1);
                chk("R5 reads", reads, ln + 1);
                chk("R5 one nack", nacks, 1);
                chk("R5 nack last", last_nack, 1);
                chk("R5 addr w", wlog[0], {ta, 1'b0});
                chk("R5 cmd", wlog[1], cm);
                chk("R5 addr r", wlog[2], {ta, 1'b1});
                rd(4'h5, d); chk("R5 data0 count", d, ln);
                rd(4'h2, d);
                for (int i = 0; i < ln; i++) begin
                    rd(4'h7, d); chk("R5 payload", d, pat(seed, i));
                end
            end
        end

        // R3: start bit reads back zero, protocol stored
        rd(4'h2, d); chk("R3 start reads 0", d, 8'h14);

        // R2: index rewind and auto-increment
        rd(4'h2, d);
        wr(4'h7, 8'hA1); wr(4'h7, 8'hB2); wr(4'h7, 8'hC3);
        rd(4'h2, d);
        rd(4'h7, d); chk("R2 idx0", d, 8'hA1);
        rd(4'h7, d); chk("R2 idx1", d, 8'hB2);
        rd(4'h2, d);
        rd(4'h7, d); chk("R2 rewind", d, 8'hA1);

        // R7: write-one clears INTR
        wr(4'h0, 8'h02);
        rd(4'h0, d); chk("R7 w1c intr", d, 0);

        // R3: wrong protocol ignored
        clear_log();
        wr(4'h2, 8'h48);
        repeat (10) @(negedge clk);
        rd(4'h0, d); chk("R3 proto ignored", d, 0);
        chk("R3 proto no bus", starts, 0);

        // R3: buffer-enable clear ignored
        wr(4'hD, 8'h00);
        wr(4'h2, 8'h54);
        repeat (10) @(negedge clk);
        rd(4'h0, d); chk("R3 aux ignored", d, 0);
        chk("R3 aux no bus", starts, 0);
        wr(4'hD, 8'h02);

        // R3: start while busy ignored
        seed = 8'h5C;
        setup_read(7'h44, 8'h09, 32);
        wr(4'h2, 8'h54);
        wr(4'h2, 8'h54);
        wait_idle(s);
        chk("R3 busy start ignored", starts, 2);
        chk("R3 busy start status", s, 8'h02);

        // R8: NACK on second payload byte
        seed = 8'h11;
        setup_write(7'h2A, 8'h01, 4);
        nack_at = 4;
        wr(4'h2, 8'h54);
        wait_idle(s);
        chk("R8 payload nack status", s, 8'h04);
        chk("R8 payload nack bytes", wcnt, 5);
        chk("R8 payload nack stop", stops, 1);

        // R8: NACK on address
        setup_read(7'h2B, 8'h01, 3);
        nack_at = 0;
        wr(4'h2, 8'h54);
        wait_idle(s);
        chk("R8 addr nack status", s, 8'h04);
        chk("R8 addr nack bytes", wcnt, 1);
        chk("R8 addr nack reads", reads, 0);

        // R9: received counts 0 and 33
        setup_read(7'h30, 8'h00, 0);
        wr(4'h2, 8'h54);
        wait_idle(s);
        chk("R9 rx count 0", s, 8'h04);
        chk("R9 rx count 0 reads", reads, 1);
        chk("R9 rx count 0 stop", stops, 1);
        setup_read(7'h30, 8'h00, 33);
        wr(4'h2, 8'h54);
        wait_idle(s);
        chk("R9 rx count 33", s, 8'h04);
        chk("R9 rx count 33 reads", reads, 1);

        // R9: write counts 0 and 40
        setup_write(7'h31, 8'h00, 0);
        wr(4'h2, 8'h54);
        wait_idle(s);
        chk("R9 tx count 0", s, 8'h04);
        chk("R9 tx count 0 bus", starts + wcnt + stops, 0);
        setup_write(7'h31, 8'h00, 40);
        wr(4'h2, 8'h54);
        wait_idle(s);
        chk("R9 tx count 40", s, 8'h04);
        chk("R9 tx count 40 bus", starts + wcnt + stops, 0);

        // R10: kill mid-write
        seed = 8'h77;
        setup_write(7'h60, 8'h3C, 32);
        wr(4'h2, 8'h54);
        repeat (30) @(negedge clk);
        wr(4'h2, 8'h56);
        wait_idle(s);
        chk("R10 kill status", s, 8'h10);
        chk("R10 kill stop", stops, 1);
        chk("R10 kill cut short", int'(wcnt < 35), 1);
        wr(4'h2, 8'h14);

        // R7: write-one clears FAILED
        wr(4'h0, 8'h10);
        rd(4'h0, d); chk("R7 w1c failed", d, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule